// File: doc/BRIEF.md
# Stride-Detecting Prefetch Engine

This block observes the demand load addresses a processor sends to its cache and looks for one constant address stride. It remembers the last demand address and the last difference between consecutive addresses. A 2-bit saturating confidence count tracks how often that difference has repeated. Once the stride is trusted, the block asks for the line one stride ahead of the current demand. The aim is to turn the first-touch misses of a regular array walk into hits.

The demand side can only be watched, so it has a valid strobe and no ready. The prefetch side is a valid/ready stream with a single holding slot. While `pf_ready_i` is low, the request in the slot stays put with a stable address. A newer request replaces the waiting one rather than queueing behind it, because a stale prefetch is worth less than a fresh one. A plain `clear_i` pin forgets the stride history, for example on a context switch.

Top module: `stride_prefetcher`

## Requirements
- R1: The first demand after reset or after a clear only records its address. It produces no stride and no prefetch.
- R2: Each later demand forms a stride equal to its address minus the previous address. The subtraction is signed and modulo 2^32, and the result becomes the recorded stride.
- R3: A 2-bit confidence count starts at 0. It steps up, saturating at 3, when a demand's stride equals the recorded stride and is nonzero. Any other demand that has a previous address sets it to 0.
- R4: A prefetch is issued on the demand whose stride matches when the updated confidence is 2 or more. Its address is that demand's address plus the stride, modulo 2^32, and it appears at the output on the next clock edge.
- R5: A zero stride never issues a prefetch, and it sets the confidence to 0.
- R6: Negative strides are detected and prefetched in the same way as positive ones.
- R7: While `pf_valid_o` is high and `pf_ready_i` is low, the request stays valid with an unchanged address. A cycle with both high consumes the request unless a new one is issued in the same cycle.
- R8: A newly issued request overwrites any request still waiting. At most one request is outstanding.
- R9: `clear_i` forgets the last address, the stride and the confidence. A demand in the same cycle as a clear is ignored. A request already waiting is kept.
- R10: After reset `pf_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Forget stride history |
| dem_valid_i | input | 1 | Demand address strobe |
| dem_addr_i | input | 32 | Demand address |
| pf_valid_o | output | 1 | Prefetch request valid |
| pf_ready_i | input | 1 | Prefetch consumer ready |
| pf_addr_o | output | 32 | Prefetch address |

## Verification
A wrong last address or stride shows at the ports as a missing, extra or misaddressed prefetch on the very next matching demand, at most one cycle after the fault. A stuck or mis-saturating confidence count shows within the next three demands of a regular stream, by firing one demand early or late. The bench walks every stream of a grid of positive, negative and zero strides and wrapping base addresses against an arithmetic model. It also runs directed stride breaks, clears and back-pressure.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;
  // How much history the detector currently holds
  typedef enum logic [1:0] {
    HIST_EMPTY = 2'd0,
    HIST_ADDR  = 2'd1,
    HIST_DELTA = 2'd2
  } hist_phase_e;
endpackage

// File: rtl/stride_pf_history.sv
module stride_pf_history
  import stride_pf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              dem_valid_i,
  input  logic [ADDR_W-1:0] dem_addr_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic [ADDR_W-1:0] delta_o
);
  hist_phase_e       phase_q;
  logic [ADDR_W-1:0] last_addr_q;
  logic [ADDR_W-1:0] last_delta_q;
  logic              take;
  logic              same;

  assign take    = dem_valid_i && !clear_i;
  assign delta_o = dem_addr_i - last_addr_q;
  assign same    = (phase_q == HIST_DELTA) && (delta_o == last_delta_q)
                   && (delta_o != '0);
  assign hit_o   = take && same;
  assign miss_o  = take && (phase_q != HIST_EMPTY) && !same;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= HIST_EMPTY;
      last_addr_q  <= '0;
      last_delta_q <= '0;
    end else if (clear_i) begin
      phase_q      <= HIST_EMPTY;
      last_addr_q  <= '0;
      last_delta_q <= '0;
    end else if (dem_valid_i) begin
      last_addr_q <= dem_addr_i;
      if (phase_q == HIST_EMPTY) begin
        phase_q <= HIST_ADDR;
      end else begin
        phase_q      <= HIST_DELTA;
        last_delta_q <= delta_o;
      end
    end
  end

  // R1: a cleared history cannot match on the following demand
  assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !hit_o);
endmodule

// File: rtl/stride_pf_conf.sv
module stride_pf_conf #(
  parameter int CONF_W   = 2,
  parameter int CONF_MIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              hit_i,
  input  logic              miss_i,
  output logic [CONF_W-1:0] conf_o,
  output logic              issue_o
);
  localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};

  logic [CONF_W-1:0] conf_q;
  logic [CONF_W-1:0] conf_up;

  assign conf_up = (conf_q == CONF_MAX) ? conf_q : conf_q + 1'b1;
  assign issue_o = hit_i && (int'(conf_up) >= CONF_MIN);
  assign conf_o  = conf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       conf_q <= '0;
    else if (clear_i) conf_q <= '0;
    else if (hit_i)   conf_q <= conf_up;
    else if (miss_i)  conf_q <= '0;
  end

  assert_conf_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_i |=> conf_q == '0);
  assert_conf_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && !clear_i && conf_q == CONF_MAX) |=> conf_q == CONF_MAX);
  assert_conf_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> conf_q == '0);
endmodule

// File: rtl/stride_pf_slot.sv
module stride_pf_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_o  <= load_addr_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !load_i) |=> (valid_o && $stable(addr_o)));
  assert_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && !load_i) |=> !valid_o);
  assert_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (valid_o && addr_o == $past(load_addr_i)));
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int ADDR_W   = 32,
  parameter int CONF_W   = 2,
  parameter int CONF_MIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              dem_valid_i,
  input  logic [ADDR_W-1:0] dem_addr_i,
  output logic              pf_valid_o,
  input  logic              pf_ready_i,
  output logic [ADDR_W-1:0] pf_addr_o
);
  logic              hit;
  logic              miss;
  logic              issue;
  logic [ADDR_W-1:0] delta;
  logic [CONF_W-1:0] conf;
  logic [ADDR_W-1:0] target;

  assign target = dem_addr_i + delta;

  stride_pf_history #(.ADDR_W(ADDR_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
    .dem_valid_i(dem_valid_i), .dem_addr_i(dem_addr_i),
    .hit_o(hit), .miss_o(miss), .delta_o(delta)
  );

  stride_pf_conf #(.CONF_W(CONF_W), .CONF_MIN(CONF_MIN)) u_conf (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
    .hit_i(hit), .miss_i(miss), .conf_o(conf), .issue_o(issue)
  );

  stride_pf_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load_i(issue), .load_addr_i(target),
    .valid_o(pf_valid_o), .ready_i(pf_ready_i), .addr_o(pf_addr_o)
  );

  // R4: an issued request never comes from a low-confidence stride
  assert_issue_conf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (hit && int'(conf) >= CONF_MIN - 1));
endmodule

// File: tb/stride_prefetcher_bench.sv
module stride_prefetcher_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear_i = 1'b0;
  logic        dem_valid_i = 1'b0;
  logic [31:0] dem_addr_i = '0;
  logic        pf_ready_i = 1'b1;
  logic        pf_valid_o;
  logic [31:0] pf_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int          m_hist = 0;   // 0 empty, 1 address, 2 address+stride
  logic [31:0] m_last = '0;
  logic [31:0] m_delta = '0;
  int          m_conf = 0;
  bit          m_pv = 0;
  logic [31:0] m_pa = '0;

  always #2 clk = ~clk;

  stride_prefetcher u_stride_prefetcher (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
    .dem_valid_i(dem_valid_i), .dem_addr_i(dem_addr_i),
    .pf_valid_o(pf_valid_o), .pf_ready_i(pf_ready_i), .pf_addr_o(pf_addr_o)
  );

  task automatic check(input string tag);
    checks++;
    if (pf_valid_o !== m_pv || (m_pv && pf_addr_o !== m_pa)) begin
      errors++;
      $display("FAIL %s: valid=%0b addr=%08h expected valid=%0b addr=%08h",
               tag, pf_valid_o, pf_addr_o, m_pv, m_pa);
    end
  endtask

  // one cycle: drive, update the model for the coming edge, check after it
  task automatic step(input bit v, input logic [31:0] a, input bit clr,
                      input bit rdy, input string tag);
    bit          iss = 0;
    logic [31:0] d;
    dem_valid_i = v; dem_addr_i = a; clear_i = clr; pf_ready_i = rdy;
    if (clr) begin
      m_hist = 0; m_conf = 0;
    end else if (v) begin
      if (m_hist == 0) begin
        m_hist = 1;
      end else begin
        d = a - m_last;
        if (m_hist == 2 && d == m_delta && d != 0) begin
          m_conf = (m_conf < 3) ? m_conf + 1 : 3;
          iss = (m_conf >= 2);
        end else begin
          m_conf = 0;
        end
        m_delta = d;
        m_hist = 2;
      end
      m_last = a;
    end
    if (iss) begin
      m_pv = 1; m_pa = a + m_delta;
    end else if (m_pv && rdy) begin
      m_pv = 0;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input bit rdy, input string tag);
    step(1'b0, 32'h0, 1'b0, rdy, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: valid=%0b addr=%08h expected run to finish",
               pf_valid_o, pf_addr_o);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] strides [8];
    logic [31:0] bases [3];
    strides = '{32'd1, 32'd4, 32'd16, 32'd64, -32'sd4, -32'sd64,
                32'h1000, -32'sd1};
    bases = '{32'h0, 32'h8000_0000, 32'hFFFF_FFF0};

    repeat (2) @(negedge clk);
    check("R10 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset release");

    // R1: lone first demand records only
    step(1, 32'h100, 0, 1, "R1 first demand");
    step(1, 32'h104, 0, 1, "R1 second demand");

    // Sweep: R2 R4 R6 across strides and wrapping bases
    foreach (bases[b]) begin
      foreach (strides[s]) begin
        step(0, 32'h0, 1, 1, "R9 clear before stream");
        for (int k = 0; k < 7; k++)
          step(1, bases[b] + strides[s] * k, 0, 1,
               (strides[s][31] ? "R6 negative stride stream" : "R4 R2 stride stream"));
      end
    end

    // R5: zero stride never prefetches and breaks confidence
    step(0, 32'h0, 1, 1, "R9 clear");
    for (int k = 0; k < 5; k++) step(1, 32'h2000, 0, 1, "R5 repeated address");
    step(0, 32'h0, 1, 1, "R9 clear");
    step(1, 32'h3000, 0, 1, "R5 setup");
    step(1, 32'h3004, 0, 1, "R5 setup");
    step(1, 32'h3008, 0, 1, "R5 setup");
    step(1, 32'h3008, 0, 1, "R5 zero stride");
    step(1, 32'h300C, 0, 1, "R5 after zero no prefetch");
    step(1, 32'h3010, 0, 1, "R3 conf one");
    step(1, 32'h3014, 0, 1, "R4 conf two prefetch");

    // R3: saturation then stride change
    for (int k = 0; k < 4; k++) step(1, 32'h3018 + 4 * k, 0, 1, "R3 saturated");
    step(1, 32'h5000, 0, 1, "R3 break stride");
    step(1, 32'h5020, 0, 1, "R3 new stride first");
    step(1, 32'h5040, 0, 1, "R3 new stride conf one");
    step(1, 32'h5060, 0, 1, "R3 new stride prefetch");

    // R7: hold under back-pressure, then drain
    step(0, 32'h0, 1, 1, "R9 clear");
    for (int k = 0; k < 4; k++) step(1, 32'h7000 + 8 * k, 0, 0, "R7 build stride");
    for (int k = 0; k < 3; k++) idle(0, "R7 held while not ready");
    idle(1, "R7 consumed");
    idle(1, "R7 stays empty");

    // R8: newer request overwrites waiting one
    step(1, 32'h7020, 0, 0, "R8 first pending");
    step(1, 32'h7028, 0, 0, "R8 overwritten");
    idle(0, "R8 hold newest");

    // R9: clear keeps pending request, forgets history, wins over demand
    step(1, 32'h7030, 1, 0, "R9 clear with demand ignored");
    idle(0, "R9 pending kept");
    step(1, 32'h7038, 0, 1, "R9 first after clear");
    step(1, 32'h7040, 0, 1, "R9 no stride yet");
    step(1, 32'h7048, 0, 1, "R9 conf one");
    step(1, 32'h7050, 0, 1, "R9 relearned prefetch");
    idle(1, "R7 drain");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule